// File: doc/BRIEF.md
# Byte-Wide Memory Boot Loader

This block runs once after reset and decides how the processor gets its first program. It captures a three-bit boot mode code while reset is held. For the byte-wide code it reads a program image from external 8-bit memory and writes it into internal program RAM as 24-bit words, then reports where execution should begin. For the other codes it raises a flag that hands control to the on-chip ROM, to a separate serial loader, or reports an unusable code.

The image begins with a six-byte header: a 24-bit word count, then a 24-bit load address. Program words follow, three bytes each. Every 24-bit value arrives low byte first, then middle, then high. Each byte read holds the read strobe for a fixed number of wait states. The internal fetch base folds down to zero on the 18-bit external address bus, so the first byte is read at external address 0. The pointer then advances by one for every byte.

Top module: `byte_boot_ctrl`

## Requirements
- R1: The mode pins, ordered {D,B,A} as bits [2:1:0], are captured while `rst` is high. Changing them after reset is released has no effect on the boot behaviour.
- R2: Code 3'b001 starts byte-wide loading. `busy` goes high and external reads begin.
- R3: Code 3'b000 sets `rom_start` high and `start_addr` to 24'hFF0000. It performs no external read and does not pulse `done`.
- R4: Codes 3'b101, 3'b110 and 3'b111 set `serial_start` high and perform no external read.
- R5: Codes 3'b010, 3'b011 and 3'b100 set `mode_invalid` high and perform no external read.
- R6: Image bytes 0..2 form the word count and bytes 3..5 form the load address. Each is assembled low byte first.
- R7: Payload word k comes from image bytes 6+3k, 7+3k and 8+3k, low byte first. It is written with a one-cycle `pram_we` to `pram_addr` equal to the load address plus k.
- R8: Each byte read holds `ext_rd` high for exactly 32 consecutive cycles (31 wait states plus the sampling cycle), with `ext_addr` stable.
- R9: The first read uses `ext_addr` 0. After each byte the address advances by one, across header and payload alike. A load of N words reads exactly 6+3N bytes.
- R10: After the last word, `done` is high for exactly one cycle. In that cycle `start_addr` equals the load address and `busy` is low.
- R11: A word count of zero makes no RAM write and pulses `done` after the six header bytes.
- R12: While `rst` is high, `ext_rd`, `pram_we`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are captured while it is high |
| mode_pins | input | 3 | Boot mode code {D,B,A} |
| ext_data | input | 8 | Byte read from external memory |
| ext_addr | output | 18 | External byte address |
| ext_rd | output | 1 | External read strobe |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | 24 | Program RAM write address |
| pram_wdata | output | 24 | Program RAM write data |
| busy | output | 1 | High while the byte-wide load runs |
| done | output | 1 | One-cycle pulse when loading finishes |
| start_addr | output | 24 | Execution start address |
| rom_start | output | 1 | ROM start mode selected |
| serial_start | output | 1 | Serial loader mode selected |
| mode_invalid | output | 1 | Reserved mode code captured |

## Verification
The bench runs a load with a zero word count. A design that writes a stray word there, or never finishes, shows up as a write or as a missing `done`. It changes the mode pins right after reset release. A design that samples them late would either skip the load or start one that should not happen. Byte order is checked against images whose header and payload bytes all differ, so a swapped low and high byte lands at the wrong RAM address or with the wrong data. Every read is timed to 32 strobe cycles and checked for a plus-one address step, which catches an off-by-one wait counter or a pointer that skips or repeats a byte.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    SEL_ROM,
    SEL_BYTE,
    SEL_SERIAL,
    SEL_BAD
  } boot_sel_t;

  function automatic boot_sel_t decode_mode(input logic [2:0] code);
    boot_sel_t s;
    case (code)
      3'b000:                 s = SEL_ROM;
      3'b001:                 s = SEL_BYTE;
      3'b101, 3'b110, 3'b111: s = SEL_SERIAL;
      default:                s = SEL_BAD;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] pins,
  output boot_sel_t         sel
);
  logic [MODE_W-1:0] code_q;

  // capture only while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (rst) code_q <= pins;
  end

  assign sel = decode_mode(code_q);
endmodule

// File: rtl/ext_byte_fetch.sv
module ext_byte_fetch #(
  parameter int          ADDR_W  = 18,
  parameter int          WAIT_ST = 31,
  parameter logic [23:0] BASE    = 24'hD00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [7:0]        ext_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic [7:0]        byte_q,
  output logic              byte_vld
);
  localparam int CNT_W = $clog2(WAIT_ST + 1) + 1;
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(WAIT_ST);
  localparam logic [ADDR_W-1:0] FOLD = BASE[ADDR_W-1:0];

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_rd   <= 1'b0;
      ext_addr <= FOLD;
      cnt      <= '0;
      byte_q   <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (ext_rd) begin
        if (cnt == LAST) begin
          byte_q   <= ext_data;
          byte_vld <= 1'b1;
          ext_rd   <= 1'b0;
          ext_addr <= ext_addr + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (go && !byte_vld) begin
        ext_rd <= 1'b1;
        cnt    <= '0;
      end
    end
  end
endmodule

// File: rtl/word_packer.sv
module word_packer #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int NBYTES = WORD_W / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0]    idx;
  logic [WORD_W-9:0]   low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      low_q <= '0;
    end else if (byte_vld) begin
      idx   <= (idx == LAST) ? '0 : idx + 1'b1;
      low_q <= {byte_in, low_q[WORD_W-9:8]};
    end
  end

  // the newest byte is the most significant one
  assign word_vld = byte_vld && (idx == LAST);
  assign word     = {byte_in, low_q};
endmodule

// File: rtl/byte_boot_ctrl.sv
module byte_boot_ctrl
  import boot_pkg::*;
#(
  parameter int          EXT_AW   = 18,
  parameter int          WORD_W   = 24,
  parameter int          WAIT_ST  = 31,
  parameter logic [23:0] ROM_BASE = 24'hFF0000,
  parameter logic [23:0] EXT_BASE = 24'hD00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_pins,
  input  logic [7:0]        ext_data,
  output logic [EXT_AW-1:0] ext_addr,
  output logic              ext_rd,
  output logic              pram_we,
  output logic [WORD_W-1:0] pram_addr,
  output logic [WORD_W-1:0] pram_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] start_addr,
  output logic              rom_start,
  output logic              serial_start,
  output logic              mode_invalid
);
  typedef enum logic [1:0] {ST_DECIDE, ST_LOAD, ST_HALT} st_t;
  typedef enum logic [1:0] {PH_CNT, PH_ADDR, PH_DATA} ph_t;

  st_t         st;
  ph_t         ph;
  boot_sel_t   sel;
  logic        go, byte_vld, word_vld;
  logic [7:0]  byte_q;
  logic [WORD_W-1:0] word, remain, wr_ptr, ld_addr;

  boot_mode_latch #(.MODE_W(3)) u_mode (
    .clk(clk), .rst(rst), .pins(mode_pins), .sel(sel)
  );

  ext_byte_fetch #(.ADDR_W(EXT_AW), .WAIT_ST(WAIT_ST), .BASE(EXT_BASE)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .ext_data(ext_data),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .byte_q(byte_q), .byte_vld(byte_vld)
  );

  word_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_q),
    .word_vld(word_vld), .word(word)
  );

  assign go = (st == ST_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_DECIDE;
      ph           <= PH_CNT;
      busy         <= 1'b0;
      done         <= 1'b0;
      rom_start    <= 1'b0;
      serial_start <= 1'b0;
      mode_invalid <= 1'b0;
      start_addr   <= '0;
      pram_we      <= 1'b0;
      pram_addr    <= '0;
      pram_wdata   <= '0;
      remain       <= '0;
      wr_ptr       <= '0;
      ld_addr      <= '0;
    end else begin
      done    <= 1'b0;
      pram_we <= 1'b0;
      case (st)
        ST_DECIDE: begin
          case (sel)
            SEL_BYTE: begin
              busy <= 1'b1;
              st   <= ST_LOAD;
            end
            SEL_ROM: begin
              rom_start  <= 1'b1;
              start_addr <= ROM_BASE[WORD_W-1:0];
              st         <= ST_HALT;
            end
            SEL_SERIAL: begin
              serial_start <= 1'b1;
              st           <= ST_HALT;
            end
            default: begin
              mode_invalid <= 1'b1;
              st           <= ST_HALT;
            end
          endcase
        end
        ST_LOAD: begin
          if (word_vld) begin
            case (ph)
              PH_CNT: begin
                remain <= word;
                ph     <= PH_ADDR;
              end
              PH_ADDR: begin
                ld_addr <= word;
                wr_ptr  <= word;
                if (remain == '0) begin
                  busy       <= 1'b0;
                  done       <= 1'b1;
                  start_addr <= word;
                  st         <= ST_HALT;
                end else begin
                  ph <= PH_DATA;
                end
              end
              default: begin
                pram_we    <= 1'b1;
                pram_addr  <= wr_ptr;
                pram_wdata <= word;
                wr_ptr     <= wr_ptr + 1'b1;
                remain     <= remain - 1'b1;
                if (remain == WORD_W'(1)) begin
                  busy       <= 1'b0;
                  done       <= 1'b1;
                  start_addr <= ld_addr;
                  st         <= ST_HALT;
                end
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/byte_boot_chk.sv
module byte_boot_chk #(
  parameter int EXT_AW  = 18,
  parameter int WAIT_ST = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_rd,
  input logic [EXT_AW-1:0] ext_addr,
  input logic              pram_we,
  input logic              busy,
  input logic              done,
  input logic              rom_start,
  input logic              serial_start,
  input logic              mode_invalid
);
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (rst)         run <= '0;
    else if (ext_rd) run <= run + 1'b1;
    else             run <= '0;
  end

  p_rd_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_rd) |-> run == 16'(WAIT_ST + 1));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && $past(ext_rd)) |-> $stable(ext_addr));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_rd) |-> ext_addr == $past(ext_addr) + 1'b1);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_we_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pram_we |=> !pram_we);

  p_no_rd_rom_r3: assert property (@(posedge clk) disable iff (rst)
    rom_start |-> !ext_rd && !done);

  p_no_rd_serial_r4: assert property (@(posedge clk) disable iff (rst)
    serial_start |-> !ext_rd);

  p_no_rd_bad_r5: assert property (@(posedge clk) disable iff (rst)
    mode_invalid |-> !ext_rd);

  p_one_mode_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, rom_start, serial_start, mode_invalid}));
endmodule

bind byte_boot_ctrl byte_boot_chk #(.EXT_AW(EXT_AW), .WAIT_ST(WAIT_ST)) u_chk (
  .clk(clk), .rst(rst), .ext_rd(ext_rd), .ext_addr(ext_addr),
  .pram_we(pram_we), .busy(busy), .done(done), .rom_start(rom_start),
  .serial_start(serial_start), .mode_invalid(mode_invalid)
);

// File: tb/test_byte_boot_ctrl.sv
module test_byte_boot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {reset mode, mode after release, word count, load address}
  localparam logic [53:0] VEC [NVEC] = '{
    {3'b001, 3'b001, 24'd3, 24'h000100},
    {3'b001, 3'b001, 24'd0, 24'h001234},
    {3'b001, 3'b001, 24'd1, 24'hABCDEF},
    {3'b001, 3'b000, 24'd2, 24'h7FFFF0},
    {3'b000, 3'b001, 24'd2, 24'h000000},
    {3'b101, 3'b101, 24'd1, 24'h000010},
    {3'b110, 3'b001, 24'd1, 24'h000010},
    {3'b111, 3'b111, 24'd1, 24'h000010},
    {3'b010, 3'b010, 24'd1, 24'h000010},
    {3'b011, 3'b001, 24'd1, 24'h000010},
    {3'b100, 3'b100, 24'd1, 24'h000010},
    {3'b001, 3'b001, 24'd4, 24'h3C5A01}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_pins = 3'b000;
  logic [7:0]  ext_data;
  logic [17:0] ext_addr;
  logic        ext_rd, pram_we, busy, done, rom_start, serial_start, mode_invalid;
  logic [23:0] pram_addr, pram_wdata, start_addr;

  int errors = 0;
  int checks = 0;
  logic [23:0] cur_cnt = '0;
  logic [23:0] cur_ld  = '0;
  bit   mon_en = 1'b0;
  int   wr_idx, rd_bytes, done_seen, run;
  bit   first_seen;
  logic prev_rd;
  logic [17:0] prev_addr;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_boot_ctrl i_byte_boot_ctrl (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .ext_data(ext_data),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .pram_we(pram_we),
    .pram_addr(pram_addr), .pram_wdata(pram_wdata), .busy(busy), .done(done),
    .start_addr(start_addr), .rom_start(rom_start),
    .serial_start(serial_start), .mode_invalid(mode_invalid)
  );

  function automatic logic [23:0] word_val(input int k, input logic [23:0] ld);
    return ld ^ (24'h5A3C00 + 24'(k) * 24'h010101);
  endfunction

  function automatic logic [7:0] img_byte(input logic [17:0] a,
                                          input logic [23:0] c, input logic [23:0] ld);
    int ai = int'(a);
    logic [23:0] w;
    if (ai < 3)      w = c >> (8 * ai);
    else if (ai < 6) w = ld >> (8 * (ai - 3));
    else             w = word_val((ai - 6) / 3, ld) >> (8 * ((ai - 6) % 3));
    return w[7:0];
  endfunction

  always @* ext_data = img_byte(ext_addr, cur_cnt, cur_ld);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // port monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst && mon_en) begin
      if (ext_rd && !prev_rd) begin
        rd_bytes++;
        if (!first_seen) begin
          check(ext_addr == 18'd0, "R9 first read address", 32'(ext_addr), 0);
          first_seen = 1'b1;
        end
      end
      if (ext_rd) run++;
      if (!ext_rd && prev_rd) begin
        check(run == 32, "R8 strobe length", 32'(run), 32);
        check(ext_addr == prev_addr + 1'b1, "R9 address step",
              32'(ext_addr), 32'(prev_addr + 1'b1));
        run = 0;
      end
      if (ext_rd && prev_rd)
        check(ext_addr == prev_addr, "R8 address hold", 32'(ext_addr), 32'(prev_addr));
      if (pram_we) begin
        check(pram_addr == cur_ld + 24'(wr_idx), "R7 write address",
              32'(pram_addr), 32'(cur_ld + 24'(wr_idx)));
        check(pram_wdata == word_val(wr_idx, cur_ld), "R7 write data",
              32'(pram_wdata), 32'(word_val(wr_idx, cur_ld)));
        wr_idx++;
      end
      if (done) done_seen++;
    end
    prev_rd   = ext_rd;
    prev_addr = ext_addr;
  end

  task automatic run_case(input logic [2:0] m0, input logic [2:0] m1,
                          input logic [23:0] c, input logic [23:0] ld);
    int n;
    mon_en = 1'b0;
    cur_cnt = c;
    cur_ld  = ld;
    mode_pins = m0;
    rst = 1'b1;
    wr_idx = 0; rd_bytes = 0; done_seen = 0; run = 0; first_seen = 1'b0;
    repeat (3) @(negedge clk);
    check(!ext_rd && !pram_we && !busy && !done, "R12 reset outputs",
          {28'd0, ext_rd, pram_we, busy, done}, 0);
    rst = 1'b0;
    mon_en = 1'b1;
    mode_pins = m1;  // R1: must be ignored from here on
    if (m0 == 3'b001) begin
      @(negedge clk);
      @(negedge clk);
      check(busy, "R2 busy after release", 32'(busy), 1);
      n = 0;
      while (!done && n < 20000) begin
        @(negedge clk);
        n++;
      end
      check(done, "R10 done seen", 32'(done), 1);
      check(start_addr == ld, "R10 start address", 32'(start_addr), 32'(ld));
      check(!busy, "R10 busy low at done", 32'(busy), 0);
      @(negedge clk);
      check(!done, "R10 done one cycle", 32'(done), 0);
      if (c == 0)
        check(wr_idx == 0, "R11 no writes for zero count", 32'(wr_idx), 0);
      else
        check(wr_idx == int'(c), "R7 write count", 32'(wr_idx), 32'(c));
      check(rd_bytes == 6 + 3 * int'(c), "R6 R9 bytes read",
            32'(rd_bytes), 32'(6 + 3 * int'(c)));
      check(done_seen == 1, "R1 R10 single done", 32'(done_seen), 1);
      repeat (100) @(negedge clk);
      check(rd_bytes == 6 + 3 * int'(c), "R1 no reads after done",
            32'(rd_bytes), 32'(6 + 3 * int'(c)));
    end else begin
      repeat (300) @(negedge clk);
      check(rd_bytes == 0 && !busy, "R1 no byte boot", 32'(rd_bytes), 0);
      check(done_seen == 0 && wr_idx == 0, "R3 R4 R5 no done or write",
            32'(done_seen + wr_idx), 0);
      if (m0 == 3'b000) begin
        check(rom_start, "R3 rom_start", 32'(rom_start), 1);
        check(start_addr == 24'hFF0000, "R3 rom address", 32'(start_addr), 32'hFF0000);
      end else if (m0 == 3'b101 || m0 == 3'b110 || m0 == 3'b111) begin
        check(serial_start && !mode_invalid, "R4 serial_start",
              {30'd0, serial_start, mode_invalid}, 2);
      end else begin
        check(mode_invalid && !serial_start && !rom_start, "R5 mode_invalid",
              {29'd0, mode_invalid, serial_start, rom_start}, 4);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NVEC; i++)
      run_case(VEC[i][53:51], VEC[i][50:48], VEC[i][47:24], VEC[i][23:0]);
    // directed: R11 zero count at a high load address, R1 pins toggling to reserved
    run_case(3'b001, 3'b011, 24'd0, 24'hFFFFFF);
    // directed: R6 R7 single word with distinct byte lanes
    run_case(3'b001, 3'b111, 24'd1, 24'h010203);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule